// File: doc/BRIEF.md
# Interrupt Source Command and Status Cell

This cell holds the interrupt state of a single peripheral interrupt source. The state is four flags: pending, under service, enable and error. A master control register sits over the flags and gates them. Software never writes a flag directly. Each write to the command register carries a 3-bit code in its top bits, and that code sets or clears one flag or a pair of flags. The current flags can be read at any time as a status byte.

Toward the system, the cell raises an interrupt request into a priority daisy-chain. It takes an acknowledge back. While the acknowledge is taken, the cell returns an 8-bit vector. The low bits of that vector can be replaced with a status code supplied by the source.

The master control register has four jobs:
- It enables or disables all requests.
- It can force the lower part of the chain to be blocked.
- It can suppress the vector.
- It can hold the cell in a software reset.

Hardware events arrive on their own input and are merged with the command writes in the same clock cycle.

Top module: `irq_src_cell`

## Requirements
- R1: A write with wrSel=0 is a command. Its code in wrData[7:5] acts on the next clock edge as follows:
  - 1 clears pending and under-service.
  - 2 sets under-service.
  - 3 clears under-service.
  - 4 sets pending.
  - 5 clears pending.
  - 6 sets enable.
  - 7 clears enable.
- R2: statusOut shows under-service at bit 7, enable at bit 6, pending at bit 5 and error at bit 4. Bits 3:0 read 0.
- R3: Code 0 changes no flag, whatever the low five bits of the written byte hold.
- R4: The error flag sets on a clock edge where a new pending event arrives while pending is already set. A new pending event is an eventIn pulse or code 4. The error flag is cleared by any command that clears pending (codes 1 and 5).
- R5: intReq is high exactly when all of these hold: master enable (control bit 7) is set, enable is set, pending is set, under-service is clear, chainIn is high and software reset is off.
- R6: A vector is written with wrSel=2. In any cycle where intAck and intReq are both high, vecValid is high and vecOut shows the vector. At the next clock edge, under-service sets.
- R7: When no-vector (control bit 5) is set, an acknowledge sets under-service but leaves vecValid low and vecOut at 0.
- R8: When vector-includes-status (control bit 4) is set, the acknowledged vector carries statusCode in bits 2:0 in place of the vector's own bits.
- R9: blockLower is high while any of these holds: under-service is set, intReq is high, or disable-lower-chain (control bit 6) is set.
- R10: While software reset (control bit 0, written with wrSel=1) is set:
  - All four flags are cleared at each clock edge.
  - Commands and events are ignored.
  - intReq is low.
  
  After the bit is written back to 0, the cell behaves normally again.
- R11: When both happen in the same cycle, an arriving event wins over a clear-pending command, and an acknowledge wins over a clear-under-service command.
- R12: After rstN is released, all flags, control bits and the vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 command, 1 master control, 2 vector |
| wrData | input | 8 | Write data |
| eventIn | input | 1 | Hardware pending event, one cycle per event |
| statusCode | input | 3 | Source status code merged into the vector |
| chainIn | input | 1 | High when no higher-priority device is in service |
| intAck | input | 1 | Interrupt acknowledge from the chain |
| statusOut | output | 8 | Flag status byte |
| intReq | output | 1 | Interrupt request |
| blockLower | output | 1 | Blocks lower-priority devices on the chain |
| vecOut | output | 8 | Returned vector, 0 when not valid |
| vecValid | output | 1 | vecOut is being driven in this cycle |

## Verification
Two pairs of functions can fall into the same cycle:
- A hardware event together with a clear-pending command.
- An acknowledge together with a clear-under-service command.

The bench provokes each pair by raising both in one cycle between two falling edges, so the same rising edge sees them together. The result is judged from the status byte that edge leaves behind. Pending must stay set while error reads clear, and under-service must end up set. A cell that lets the command win shows those bits at 0.

// File: rtl/irq_cell_pkg.sv
package irq_cell_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_CLR_BOTH = 3'd1,
    CMD_SET_IUS  = 3'd2,
    CMD_CLR_IUS  = 3'd3,
    CMD_SET_IP   = 3'd4,
    CMD_CLR_IP   = 3'd5,
    CMD_SET_IE   = 3'd6,
    CMD_CLR_IE   = 3'd7
  } irqCmd_e;

  typedef enum logic [1:0] {
    SEL_CMD = 2'd0,
    SEL_CTL = 2'd1,
    SEL_VEC = 2'd2
  } wrSel_e;

  // Master control bit positions
  localparam int CTL_MIE = 7;
  localparam int CTL_DLC = 6;
  localparam int CTL_NV  = 5;
  localparam int CTL_VIS = 4;
  localparam int CTL_RST = 0;

  localparam int CMD_W = 3;

  typedef struct packed {
    logic setIp;
    logic clrIp;
    logic setIus;
    logic clrIus;
    logic setIe;
    logic clrIe;
    logic swRst;
  } irqStrobe_t;

endpackage

// File: rtl/irq_cell_ctl.sv
module irq_cell_ctl
  import irq_cell_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output irqStrobe_t        strobe,
  output logic              mie,
  output logic              dlc,
  output logic              noVec,
  output logic              vis,
  output logic              vecWr
);

  logic    mieR, dlcR, nvR, visR, rstR;
  logic    ctlWr, cmdWr;
  irqCmd_e cmd;

  assign ctlWr = wrEn && (wrSel == SEL_CTL);
  assign cmdWr = wrEn && (wrSel == SEL_CMD) && !rstR;
  assign vecWr = wrEn && (wrSel == SEL_VEC);
  assign cmd   = irqCmd_e'(wrData[DATA_W-1 -: CMD_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mieR <= 1'b0;
      dlcR <= 1'b0;
      nvR  <= 1'b0;
      visR <= 1'b0;
      rstR <= 1'b0;
    end else if (ctlWr) begin
      mieR <= wrData[CTL_MIE];
      dlcR <= wrData[CTL_DLC];
      nvR  <= wrData[CTL_NV];
      visR <= wrData[CTL_VIS];
      rstR <= wrData[CTL_RST];
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.swRst = rstR;
    if (cmdWr) begin
      unique case (cmd)
        CMD_CLR_BOTH: begin
          strobe.clrIp  = 1'b1;
          strobe.clrIus = 1'b1;
        end
        CMD_SET_IUS: strobe.setIus = 1'b1;
        CMD_CLR_IUS: strobe.clrIus = 1'b1;
        CMD_SET_IP:  strobe.setIp  = 1'b1;
        CMD_CLR_IP:  strobe.clrIp  = 1'b1;
        CMD_SET_IE:  strobe.setIe  = 1'b1;
        CMD_CLR_IE:  strobe.clrIe  = 1'b1;
        default: ;
      endcase
    end
  end

  assign mie   = mieR;
  assign dlc   = dlcR;
  assign noVec = nvR;
  assign vis   = visR;

  AST_ONE_SET_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setIp, strobe.setIus, strobe.setIe, strobe.clrIe})); // R1

  AST_RST_MUTES_CMD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swRst |-> !(strobe.setIp || strobe.clrIp || strobe.setIus ||
                       strobe.clrIus || strobe.setIe || strobe.clrIe)); // R10

endmodule

// File: rtl/irq_cell_dp.sv
module irq_cell_dp
  import irq_cell_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strobe,
  input  logic              mie,
  input  logic              dlc,
  input  logic              noVec,
  input  logic              vis,
  input  logic              vecWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eventIn,
  input  logic              chainIn,
  input  logic              intAck,
  input  logic [CODE_W-1:0] statusCode,
  output logic [DATA_W-1:0] statusOut,
  output logic              intReq,
  output logic              blockLower,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid
);

  localparam int FLAG_N = 4;
  localparam int LOW_W  = DATA_W - FLAG_N;

  logic              ip, ius, ie, err;
  logic              newEvt, ackTake;
  logic [DATA_W-1:0] vecReg, vecMix;

  assign newEvt  = eventIn | strobe.setIp;
  assign ackTake = intAck & intReq;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.swRst) begin
      ip  <= 1'b0;
      ius <= 1'b0;
      ie  <= 1'b0;
      err <= 1'b0;
    end else begin
      ip  <= newEvt | (ip & ~strobe.clrIp);
      err <= strobe.clrIp ? 1'b0 : (err | (newEvt & ip));
      ius <= ackTake | strobe.setIus | (ius & ~strobe.clrIus);
      ie  <= strobe.setIe | (ie & ~strobe.clrIe);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) vecReg <= '0;
    else if (vecWr) vecReg <= wrData;
  end

  assign intReq     = mie & ie & ip & ~ius & chainIn & ~strobe.swRst;
  assign blockLower = ius | intReq | dlc;
  assign statusOut  = {ius, ie, ip, err, {LOW_W{1'b0}}};

  // Per-bit vector merge: low CODE_W bits may carry the source status code
  for (genvar i = 0; i < DATA_W; i++) begin : g_vec
    if (i < CODE_W) begin : g_code
      assign vecMix[i] = vis ? statusCode[i] : vecReg[i];
    end else begin : g_base
      assign vecMix[i] = vecReg[i];
    end
  end

  assign vecValid = ackTake & ~noVec;
  assign vecOut   = vecValid ? vecMix : '0;

  AST_ACK_SETS_IUS: assert property (@(posedge clk) disable iff (!rstN)
    ackTake |=> ius); // R6

  AST_ERR_NEEDS_IP: assert property (@(posedge clk) disable iff (!rstN)
    err |-> ip); // R4

  AST_NULL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (!(strobe.setIp || strobe.clrIp || strobe.setIus || strobe.clrIus ||
       strobe.setIe || strobe.clrIe) && !eventIn && !ackTake && !strobe.swRst)
    |=> $stable({ip, ius, ie, err})); // R3

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swRst |=> !(ip || ius || ie || err)); // R10

  AST_NOVEC_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && noVec) |-> !vecValid && (vecOut == '0)); // R7

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_cell_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eventIn,
  input  logic [CODE_W-1:0] statusCode,
  input  logic              chainIn,
  input  logic              intAck,
  output logic [DATA_W-1:0] statusOut,
  output logic              intReq,
  output logic              blockLower,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid
);

  irqStrobe_t strobe;
  logic       mie, dlc, noVec, vis, vecWr;

  irq_cell_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strobe (strobe),
    .mie    (mie),
    .dlc    (dlc),
    .noVec  (noVec),
    .vis    (vis),
    .vecWr  (vecWr)
  );

  irq_cell_dp #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .mie        (mie),
    .dlc        (dlc),
    .noVec      (noVec),
    .vis        (vis),
    .vecWr      (vecWr),
    .wrData     (wrData),
    .eventIn    (eventIn),
    .chainIn    (chainIn),
    .intAck     (intAck),
    .statusCode (statusCode),
    .statusOut  (statusOut),
    .intReq     (intReq),
    .blockLower (blockLower),
    .vecOut     (vecOut),
    .vecValid   (vecValid)
  );

endmodule

// File: tb/sim_irq_src_cell.sv
`timescale 1ns/1ps
module sim_irq_src_cell;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic       eventIn = 1'b0;
  logic [2:0] statusCode = 3'd0;
  logic       chainIn = 1'b1;
  logic       intAck = 1'b0;
  logic [7:0] statusOut;
  logic       intReq, blockLower, vecValid;
  logic [7:0] vecOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_src_cell u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .eventIn(eventIn), .statusCode(statusCode), .chainIn(chainIn),
    .intAck(intAck), .statusOut(statusOut), .intReq(intReq),
    .blockLower(blockLower), .vecOut(vecOut), .vecValid(vecValid)
  );

  // {command byte, expected status byte} walked from a cleared cell
  localparam logic [15:0] CMD_TABLE [12] = '{
    16'hC0_40,  // R1 set enable
    16'h80_60,  // R1 set pending
    16'h80_70,  // R4 second pending sets error
    16'hA0_40,  // R4 clear pending drops error
    16'h40_C0,  // R1 set under-service
    16'h60_40,  // R1 clear under-service
    16'h80_60,  // R1 set pending
    16'h40_E0,  // R2 all three flags in their bit places
    16'h20_40,  // R1 clear pending and under-service
    16'h1F_40,  // R3 null code with low bits set
    16'hE0_00,  // R1 clear enable
    16'h00_00   // R3 null code from empty
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic pulseEvent();
    @(negedge clk);
    eventIn = 1'b1;
    @(negedge clk);
    eventIn = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 status", statusOut, 8'h00);
    check("R12 intReq", intReq, 0);
    check("R12 blockLower", blockLower, 0);
    check("R12 vecValid", vecValid, 0);

    // Table walk: commands and status layout
    for (int i = 0; i < 12; i++) begin
      wr(2'd0, CMD_TABLE[i][15:8]);
      check($sformatf("R1/R2/R3/R4 row %0d", i), statusOut, CMD_TABLE[i][7:0]);
    end

    // R5 request conditions
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hC0);
    check("R5 no request without pending", intReq, 0);
    pulseEvent();
    check("R5 request", intReq, 1);
    check("R9 blockLower while requesting", blockLower, 1);
    @(negedge clk); chainIn = 1'b0; #1;
    check("R5 chainIn low masks request", intReq, 0);
    chainIn = 1'b1;
    wr(2'd1, 8'h00);
    check("R5 master enable off", intReq, 0);
    wr(2'd1, 8'h80);
    check("R5 request returns", intReq, 1);

    // R6 acknowledge with plain vector
    wr(2'd2, 8'hA5);
    check("R6 no vector without ack", vecValid, 0);
    @(negedge clk); intAck = 1'b1; #1;
    check("R6 vecValid", vecValid, 1);
    check("R6 vecOut", vecOut, 8'hA5);
    @(negedge clk); intAck = 1'b0;
    check("R6 under-service set", statusOut, 8'hE0);
    check("R5 request drops in service", intReq, 0);
    check("R9 blockLower in service", blockLower, 1);

    // R8 vector includes status
    wr(2'd1, 8'h90);
    statusCode = 3'b110;
    wr(2'd0, 8'h60);
    check("R8 re-request", intReq, 1);
    @(negedge clk); intAck = 1'b1; #1;
    check("R8 vecOut with code", vecOut, 8'hA6);
    @(negedge clk); intAck = 1'b0;

    // R7 no-vector
    wr(2'd1, 8'hA0);
    wr(2'd0, 8'h60);
    @(negedge clk); intAck = 1'b1; #1;
    check("R7 vecValid low", vecValid, 0);
    check("R7 vecOut zero", vecOut, 8'h00);
    @(negedge clk); intAck = 1'b0;
    check("R7 under-service still set", statusOut, 8'hE0);

    // R11 ack and clear-under-service in one cycle
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h60);
    check("R11 pre request", intReq, 1);
    @(negedge clk);
    intAck = 1'b1; wrEn = 1'b1; wrSel = 2'd0; wrData = 8'h60;
    @(negedge clk);
    intAck = 1'b0; wrEn = 1'b0; wrData = 8'h00;
    check("R11 ack beats clear-IUS", statusOut, 8'hE0);

    // R11 event and clear-pending in one cycle
    wr(2'd0, 8'h20);
    check("R1 clear both", statusOut, 8'h40);
    wr(2'd0, 8'h80);
    @(negedge clk);
    eventIn = 1'b1; wrEn = 1'b1; wrSel = 2'd0; wrData = 8'hA0;
    @(negedge clk);
    eventIn = 1'b0; wrEn = 1'b0; wrData = 8'h00;
    check("R11 event beats clear-IP", statusOut, 8'h60);
    pulseEvent();
    check("R4 event on pending sets error", statusOut, 8'h70);

    // R9 disable-lower-chain forcing
    wr(2'd0, 8'h20);
    wr(2'd0, 8'hE0);
    wr(2'd1, 8'h40);
    check("R9 forced block", blockLower, 1);
    wr(2'd1, 8'h00);
    check("R9 block released", blockLower, 0);

    // R10 software reset
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hC0);
    wr(2'd0, 8'h80);
    check("R10 pre state", statusOut, 8'h60);
    wr(2'd1, 8'h81);
    check("R10 request off", intReq, 0);
    @(negedge clk);
    check("R10 flags cleared", statusOut, 8'h00);
    wr(2'd0, 8'hC0);
    pulseEvent();
    check("R10 command and event ignored", statusOut, 8'h00);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hC0);
    check("R10 works after release", statusOut, 8'h40);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule